// File: doc/BRIEF.md
# Multi-Rail Power-Good and Reset Supervisor

This block watches up to eight supply rails and reports on each of them. Every rail arrives as a digital undervoltage flag from a comparator outside the block. Each channel drives its own power-good output. A shared system reset output covers the whole set of rails. The block runs from a single clock of known frequency, and all of its delays come from counters.

A power-good output falls as soon as its rail is flagged low or the forcing input is high. It rises again only after its rail has stayed clean for 6.25 ms. The system reset falls when any rail is low or when the manual reset input is held low. It releases once every cause has stayed absent for a programmable number of cycles.

A margin hold input, active low, freezes every output and every timeout counter while supplies are margined. This hold takes priority over the manual reset. All asynchronous inputs pass through a two-flop synchronizer before the block uses them.

Top module: `supply_supervisor`

## Requirements
- R1: A low-causing condition on a channel (its `rail_low` bit is 1, or `force_off` is 1) drives `pg` for that channel to 0 at the third rising clock edge after the input changes. The delay is two synchronizer stages plus the output register.
- R2: Once the synchronized cause has cleared, `pg` of a channel rises after PG_CYCLES = CLK_HZ/160 consecutive clean, non-held cycles, which is 6.25 ms.
- R3: `force_off` at 1 drives every `pg` bit to 0, and it does not affect `sys_rst_n`.
- R4: `sys_rst_n` goes to 0 when any `rail_low` bit is 1 or when `mrst_n` is 0.
- R5: `sys_rst_n` returns to 1 only after RST_CYCLES consecutive clean, non-held cycles.
- R6: If a cause returns while a timeout is running, that counter restarts from zero and its output stays 0.
- R7: While the synchronized `hold_n` is 0, `pg` and `sys_rst_n` keep their present values, whatever the rails and the forcing input do.
- R8: When `hold_n` and `mrst_n` are both 0, the hold wins and `sys_rst_n` stays frozen.
- R9: While held, the timeout counters keep their values. After the hold is released they resume from those values rather than restarting.
- R10: While `rst_n` is 0, all `pg` bits and `sys_rst_n` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rail_low | input | CHANNELS | Undervoltage flag per rail, 1 = below threshold |
| force_off | input | 1 | Forces all power-good outputs low when 1 |
| mrst_n | input | 1 | Manual reset, active low |
| hold_n | input | 1 | Margin hold, active low, freezes outputs and counters |
| pg | output | CHANNELS | Power-good per channel, 1 = good |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
The bench goes after a glitch that arrives part way through a timeout. A design that resumes counting instead of restarting would release the output too early. It also applies the margin hold while counters are mid-count. If the counters were cleared, the release would come late; if they kept running, outputs would move while frozen. Manual reset and hold are asserted together to catch a design that lets the manual reset through the hold. A behavioural model that counts the synchronizer delay independently catches any one-cycle error in latency or timeout length.

// File: rtl/supply_supervisor.sv
module supply_supervisor #(
  parameter int CHANNELS   = 8,
  parameter int CLK_HZ     = 100_000_000,
  parameter int RST_CYCLES = 2_000_000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] rail_low,
  input  logic                force_off,
  input  logic                mrst_n,
  input  logic                hold_n,
  output logic [CHANNELS-1:0] pg,
  output logic                sys_rst_n
);

  localparam int PG_CYCLES = CLK_HZ / 160;
  localparam int PW        = $clog2(PG_CYCLES + 1);
  localparam int RW        = $clog2(RST_CYCLES + 1);
  localparam int SW        = CHANNELS + 3;
  localparam logic [SW-1:0] SYNC_INIT = {2'b11, 1'b0, {CHANNELS{1'b0}}};

  logic [SW-1:0] meta, sync;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta <= SYNC_INIT;
      sync <= SYNC_INIT;
    end else begin
      meta <= {hold_n, mrst_n, force_off, rail_low};
      sync <= meta;
    end

  wire [CHANNELS-1:0] low_s  = sync[CHANNELS-1:0];
  wire                en_s   = sync[CHANNELS];
  wire                mr_s   = sync[CHANNELS+1];
  wire                hold_s = ~sync[CHANNELS+2];

  for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
    logic [PW-1:0] cnt;
    wire cause = low_s[i] | en_s;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt   <= '0;
        pg[i] <= 1'b0;
      end else if (!hold_s) begin
        if (cause) begin
          cnt   <= '0;
          pg[i] <= 1'b0;
        end else if (!pg[i]) begin
          if (cnt == PW'(PG_CYCLES - 1)) begin
            cnt   <= '0;
            pg[i] <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end

    AST_PG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_s && cause) |=> !pg[i]);  // R1
    AST_PG_RISE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pg[i]) |-> $past(!cause && !hold_s));  // R2
    AST_PG_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < PW'(PG_CYCLES));  // R6
  end

  logic [RW-1:0] rcnt;
  wire rcause = (|low_s) | ~mr_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rcnt      <= '0;
      sys_rst_n <= 1'b0;
    end else if (!hold_s) begin
      if (rcause) begin
        rcnt      <= '0;
        sys_rst_n <= 1'b0;
      end else if (!sys_rst_n) begin
        if (rcnt == RW'(RST_CYCLES - 1)) begin
          rcnt      <= '0;
          sys_rst_n <= 1'b1;
        end else begin
          rcnt <= rcnt + 1'b1;
        end
      end
    end

  AST_RST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_s && rcause) |=> !sys_rst_n);  // R4
  AST_RST_RISE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> $past(!rcause && !hold_s));  // R5
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_s |=> ($stable(pg) && $stable(sys_rst_n)));  // R7
  AST_HOLD_BEATS_MR: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_s && !mr_s && sys_rst_n) |=> sys_rst_n);  // R8
  AST_RST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt < RW'(RST_CYCLES));  // R5

endmodule

// File: tb/tb_supply_supervisor.sv
module tb_supply_supervisor;
  localparam int N   = 8;
  localparam int HZ  = 3200;
  localparam int RC  = 12;
  localparam int PGC = HZ / 160;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] rail_low = '0;
  logic force_off = 1'b0, mrst_n = 1'b1, hold_n = 1'b1;
  logic [N-1:0] pg;
  logic sys_rst_n;

  supply_supervisor #(.CHANNELS(N), .CLK_HZ(HZ), .RST_CYCLES(RC)) dut (
    .clk(clk), .rst_n(rst_n), .rail_low(rail_low), .force_off(force_off),
    .mrst_n(mrst_n), .hold_n(hold_n), .pg(pg), .sys_rst_n(sys_rst_n));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  string tag = "R10";

  // behavioural reference
  logic [N-1:0] q1_rail, q2_rail;
  logic [2:0]   q1_ctl, q2_ctl;  // {hold_n, mrst_n, force_off}
  int  pcnt [N];
  bit  pgm  [N];
  int  rcnt_m;
  bit  rst_m;

  task automatic check(input string req, input logic [N:0] act, input logic [N:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual pg/rst=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1_rail = '0; q2_rail = '0; q1_ctl = 3'b110; q2_ctl = 3'b110;
      for (int i = 0; i < N; i++) begin pcnt[i] = 0; pgm[i] = 0; end
      rcnt_m = 0; rst_m = 0;
    end else begin
      if (q2_ctl[2]) begin
        for (int i = 0; i < N; i++) begin
          if (q2_rail[i] || q2_ctl[0]) begin pcnt[i] = 0; pgm[i] = 0; end
          else if (!pgm[i]) begin
            pcnt[i]++;
            if (pcnt[i] == PGC) begin pgm[i] = 1; pcnt[i] = 0; end
          end
        end
        if ((|q2_rail) || !q2_ctl[1]) begin rcnt_m = 0; rst_m = 0; end
        else if (!rst_m) begin
          rcnt_m++;
          if (rcnt_m == RC) begin rst_m = 1; rcnt_m = 0; end
        end
      end
      q2_rail = q1_rail; q2_ctl = q1_ctl;
      q1_rail = rail_low; q1_ctl = {hold_n, mrst_n, force_off};
    end
  end

  always @(posedge clk) begin
    #1;
    begin
      logic [N:0] e;
      for (int i = 0; i < N; i++) e[i] = pgm[i];
      e[N] = rst_m;
      check(tag, {sys_rst_n, pg}, e);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tag = "R10";
    wait_cyc(3);
    check("R10", {sys_rst_n, pg}, '0);
    rst_n = 1'b1;
    tag = "R2";                       // R5 timed in the same window
    wait_cyc(40);
    check("R2", {sys_rst_n, pg}, {1'b1, {N{1'b1}}});
    tag = "R1";                       // rail 2 drops, R4 on reset
    rail_low[2] = 1'b1; wait_cyc(5); rail_low[2] = 1'b0;
    wait_cyc(30);
    tag = "R6";
    rail_low[3] = 1'b1; wait_cyc(3); rail_low[3] = 1'b0;
    wait_cyc(10);
    rail_low[3] = 1'b1; wait_cyc(2); rail_low[3] = 1'b0;
    wait_cyc(14);
    check("R6", {1'b0, pg[3]}, {1'b0, 1'b0});
    wait_cyc(20);
    tag = "R3";
    force_off = 1'b1; wait_cyc(5); force_off = 1'b0;
    wait_cyc(30);
    tag = "R4";
    mrst_n = 1'b0; wait_cyc(4); mrst_n = 1'b1;
    wait_cyc(25);
    tag = "R7";
    hold_n = 1'b0; wait_cyc(3);
    rail_low = 8'hA5; force_off = 1'b1; wait_cyc(10);
    rail_low = '0; force_off = 1'b0; wait_cyc(4);
    check("R7", {sys_rst_n, pg}, {1'b1, {N{1'b1}}});
    hold_n = 1'b1; wait_cyc(10);
    tag = "R8";
    hold_n = 1'b0; wait_cyc(3); mrst_n = 1'b0; wait_cyc(8);
    check("R8", {1'b0, sys_rst_n}, {1'b0, 1'b1});
    mrst_n = 1'b1; wait_cyc(4); hold_n = 1'b1;
    wait_cyc(10);
    tag = "R9";
    rail_low[5] = 1'b1; mrst_n = 1'b0; wait_cyc(3);
    rail_low[5] = 1'b0; mrst_n = 1'b1; wait_cyc(10);
    hold_n = 1'b0; wait_cyc(15); hold_n = 1'b1;
    wait_cyc(30);
    tag = "R1";
    rail_low = 8'hFF; wait_cyc(4); rail_low = '0;
    wait_cyc(40);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule